// File: doc/BRIEF.md
# PLL Retune Sequencer

This block changes the frequency of a PLL-derived system clock without ever reprogramming the PLL while it drives the system. A one-cycle request carries a 6-bit multiplier code and a 4-bit divider code. The sequencer first moves the system clock onto the oscillator. It then checks that the requested PLL output is a whole number of MHz inside the permitted band. If the check passes, it writes the new codes and waits for a filtered lock indication before it moves the system clock back onto the PLL.

The PLL output frequency is 2 × OSC_MHZ × (mult+1) / (div+1), and the bus clock is half of that. A request that fails validation, or whose lock never qualifies before the timeout runs out, leaves the oscillator in charge and raises a sticky error. The `bus_mhz` output always reports the frequency in force: the oscillator frequency while the oscillator is the source, and half the PLL output once the PLL is selected.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, `sel_pll`=0, `busy`=0, `err`=0, `mult_q`=0, `div_q`=0 and `bus_mhz`=OSC_MHZ.
- R2: A request sampled while idle takes effect on that clock edge (call it E0). At E0, `sel_pll` drops to 0 (0 means oscillator), `bus_mhz` becomes OSC_MHZ and `busy` rises. Neither code register changes at E0. `sel_pll` stays 0 for as long as `busy` is high.
- R3: When a request is accepted, `mult_q` and `div_q` take the requested codes at edge E1. On success, `bus_mhz` = OSC_MHZ × (mult+1)/(div+1). With OSC_MHZ=16: (2,1) gives 24, (8,15) gives 9 and (0,0) gives 16.
- R4: A request whose PLL output is not an exact integer is rejected at E1: `err`=1, `busy`=0, `sel_pll`=0 and `bus_mhz`=OSC_MHZ. The code registers keep their old values. Example: (0,2).
- R5: The PLL output must lie in 16..50 MHz inclusive. (0,1) gives 16 and (24,15) gives 50; both are accepted. (6,15) gives 14, (12,7) gives 52 and (3,0) gives 128; all three are rejected as in R4.
- R6: Lock counts only after `pll_lock` has been high on LOCK_FILT consecutive cycles of the wait. If `pll_lock` is high from E2 onward, the PLL is selected at edge E(1+LOCK_FILT). Shorter runs select nothing.
- R7: If no qualifying lock occurs within LOCK_TMO wait cycles, the attempt fails at edge E(LOCK_TMO+1). `busy` then falls, `err` rises, `sel_pll` stays 0 and `bus_mhz` stays OSC_MHZ.
- R8: `sel_pll` rises only on a qualified lock. On that same edge, `bus_mhz` takes the new bus frequency and `busy` falls.
- R9: A request that arrives while `busy` is high is ignored. It changes neither the codes nor the result, and it starts no further sequence.
- R10: `err` holds until the next accepted request, which clears it at E0. `err` and `busy` are never both high.
- R11: `mult_q` and `div_q` never change while the PLL is the system source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle retune request |
| req_mult | input | MULT_W | Requested multiplier code |
| req_div | input | DIV_W | Requested divider code |
| pll_lock | input | 1 | Raw lock indication from the PLL |
| sel_pll | output | 1 | Clock source select, 1 = PLL, 0 = oscillator |
| mult_q | output | MULT_W | Multiplier code programmed into the PLL |
| div_q | output | DIV_W | Divider code programmed into the PLL |
| busy | output | 1 | Retune in progress |
| err | output | 1 | Sticky failure of the last request |
| bus_mhz | output | FREQ_W | Current bus frequency in MHz |

## Verification
The checker assumes that `pll_lock` can only matter while the sequencer is waiting. It also assumes that each request is a single-cycle pulse sampled on the rising edge, and that the default OSC_MHZ keeps every accepted bus frequency inside FREQ_W. The bench changes `req`, the codes and `pll_lock` only on falling edges. It issues every request as a one-cycle pulse and holds lock low or high for whole cycles. Each wait therefore stays below the timeout unless a test means to hit it, and the busy-window bound in the checker keeps its meaning.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EVAL = 2'd1,
      ST_WAIT = 2'd2
   } retune_state_t;

endpackage

// File: rtl/prs_validator.sv
module prs_validator #(
   parameter int OSC_MHZ  = 16,
   parameter int MULT_W   = 6,
   parameter int DIV_W    = 4,
   parameter int FMIN_MHZ = 16,
   parameter int FMAX_MHZ = 50,
   parameter int FREQ_W   = 8
) (
   input  logic [MULT_W-1:0] mult,
   input  logic [DIV_W-1:0]  div,
   output logic              ok,
   output logic [FREQ_W-1:0] bus_new
);
   localparam int NUM_W = $clog2(2 * OSC_MHZ * (2 ** MULT_W) + 1);
   localparam logic [NUM_W-1:0] OSC2   = NUM_W'(2 * OSC_MHZ);
   localparam logic [NUM_W-1:0] FMIN_N = NUM_W'(FMIN_MHZ);
   localparam logic [NUM_W-1:0] FMAX_N = NUM_W'(FMAX_MHZ);

   logic [NUM_W-1:0] mult_p1, den, num, quo, rem;

   always_comb begin
      mult_p1 = NUM_W'(mult) + NUM_W'(1);
      den     = NUM_W'(div) + NUM_W'(1);
      num     = mult_p1 * OSC2;
      quo     = num / den;
      rem     = num % den;
      ok      = (rem == '0) && (quo >= FMIN_N) && (quo <= FMAX_N);
      bus_new = FREQ_W'(quo >> 1);
   end
endmodule

// File: rtl/prs_lock_filter.sv
module prs_lock_filter #(
   parameter int LOCK_FILT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic lock,
   output logic hit
);
   generate
      if (LOCK_FILT == 1) begin : g_direct
         logic unused_ins;
         assign unused_ins = clk ^ rst_n ^ clr;
         assign hit = en && lock;
      end else begin : g_count
         localparam int RW = $clog2(LOCK_FILT + 1);
         localparam logic [RW-1:0] LAST = RW'(LOCK_FILT - 1);
         logic [RW-1:0] run;
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               run <= '0;
            end else if (en) begin
               if (!lock)          run <= '0;
               else if (run != LAST) run <= run + RW'(1);
            end
         end
         assign hit = en && lock && (run == LAST);
      end
   endgenerate
endmodule

// File: rtl/prs_timer.sv
module prs_timer #(
   parameter int LOCK_TMO = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic expired
);
   localparam int TW = $clog2(LOCK_TMO + 1);
   localparam logic [TW-1:0] LAST = TW'(LOCK_TMO - 1);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)           cnt <= '0;
      else if (en && cnt != LAST)  cnt <= cnt + TW'(1);
   end

   assign expired = en && (cnt == LAST);
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
   import pll_retune_pkg::*;
#(
   parameter int OSC_MHZ   = 16,
   parameter int MULT_W    = 6,
   parameter int DIV_W     = 4,
   parameter int FMIN_MHZ  = 16,
   parameter int FMAX_MHZ  = 50,
   parameter int LOCK_FILT = 4,
   parameter int LOCK_TMO  = 1000,
   parameter int FREQ_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [MULT_W-1:0] req_mult,
   input  logic [DIV_W-1:0]  req_div,
   input  logic              pll_lock,
   output logic              sel_pll,
   output logic [MULT_W-1:0] mult_q,
   output logic [DIV_W-1:0]  div_q,
   output logic              busy,
   output logic              err,
   output logic [FREQ_W-1:0] bus_mhz
);
   localparam logic [FREQ_W-1:0] OSC_F = FREQ_W'(OSC_MHZ);

   generate
      if (FMIN_MHZ > FMAX_MHZ) begin : g_bad_band
         $error("pll_retune_seq: FMIN_MHZ above FMAX_MHZ");
      end
      if (LOCK_FILT < 1 || LOCK_TMO <= LOCK_FILT) begin : g_bad_wait
         $error("pll_retune_seq: need 1 <= LOCK_FILT < LOCK_TMO");
      end
      if (OSC_MHZ >= (2 ** FREQ_W) || FMAX_MHZ / 2 >= (2 ** FREQ_W)) begin : g_bad_freq_w
         $error("pll_retune_seq: FREQ_W too narrow");
      end
   endgenerate

   retune_state_t     st;
   logic [MULT_W-1:0] cand_mult;
   logic [DIV_W-1:0]  cand_div;
   logic              cand_ok;
   logic [FREQ_W-1:0] cand_bus;
   logic              lock_hit, tmo_hit;
   logic              wait_clr, wait_en;

   assign wait_clr = (st == ST_EVAL);
   assign wait_en  = (st == ST_WAIT);

   prs_validator #(
      .OSC_MHZ(OSC_MHZ), .MULT_W(MULT_W), .DIV_W(DIV_W),
      .FMIN_MHZ(FMIN_MHZ), .FMAX_MHZ(FMAX_MHZ), .FREQ_W(FREQ_W)
   ) u_val (
      .mult(cand_mult), .div(cand_div), .ok(cand_ok), .bus_new(cand_bus)
   );

   prs_lock_filter #(.LOCK_FILT(LOCK_FILT)) u_filt (
      .clk(clk), .rst_n(rst_n), .clr(wait_clr), .en(wait_en),
      .lock(pll_lock), .hit(lock_hit)
   );

   prs_timer #(.LOCK_TMO(LOCK_TMO)) u_tmo (
      .clk(clk), .rst_n(rst_n), .clr(wait_clr), .en(wait_en), .expired(tmo_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cand_mult <= '0;
         cand_div  <= '0;
         sel_pll   <= 1'b0;
         mult_q    <= '0;
         div_q     <= '0;
         busy      <= 1'b0;
         err       <= 1'b0;
         bus_mhz   <= OSC_F;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (req) begin
                  cand_mult <= req_mult;
                  cand_div  <= req_div;
                  sel_pll   <= 1'b0;
                  bus_mhz   <= OSC_F;
                  busy      <= 1'b1;
                  err       <= 1'b0;
                  st        <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (cand_ok) begin
                  mult_q <= cand_mult;
                  div_q  <= cand_div;
                  st     <= ST_WAIT;
               end else begin
                  err  <= 1'b1;
                  busy <= 1'b0;
                  st   <= ST_IDLE;
               end
            end
            ST_WAIT: begin
               if (lock_hit) begin
                  sel_pll <= 1'b1;
                  bus_mhz <= cand_bus;
                  busy    <= 1'b0;
                  st      <= ST_IDLE;
               end else if (tmo_hit) begin
                  err  <= 1'b1;
                  busy <= 1'b0;
                  st   <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pll_retune_chk.sv
module pll_retune_chk #(
   parameter int OSC_MHZ   = 16,
   parameter int MULT_W    = 6,
   parameter int DIV_W     = 4,
   parameter int FMIN_MHZ  = 16,
   parameter int FMAX_MHZ  = 50,
   parameter int LOCK_TMO  = 1000,
   parameter int FREQ_W    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pll_lock,
   input logic              sel_pll,
   input logic [MULT_W-1:0] mult_q,
   input logic [DIV_W-1:0]  div_q,
   input logic              busy,
   input logic              err,
   input logic [FREQ_W-1:0] bus_mhz
);
   localparam int CW = $clog2(LOCK_TMO + 3);
   logic [CW-1:0] bcnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                                bcnt <= '0;
      else if (!busy)                            bcnt <= '0;
      else if (bcnt != CW'(LOCK_TMO + 2))        bcnt <= bcnt + CW'(1);
   end

   assert_osc_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sel_pll);

   assert_bus_on_osc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_pll |-> bus_mhz == FREQ_W'(OSC_MHZ));

   assert_band_on_pll_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sel_pll |-> (bus_mhz >= FREQ_W'(FMIN_MHZ / 2)) && (bus_mhz <= FREQ_W'(FMAX_MHZ / 2)));

   assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bcnt <= CW'(LOCK_TMO + 1));

   assert_select_on_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_pll) |-> $past(pll_lock) && $past(busy) && $fell(busy));

   assert_err_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && err));

   assert_codes_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(mult_q) || !$stable(div_q)) |-> !$past(sel_pll) && !sel_pll);
endmodule

bind pll_retune_seq pll_retune_chk #(
   .OSC_MHZ(OSC_MHZ), .MULT_W(MULT_W), .DIV_W(DIV_W), .FMIN_MHZ(FMIN_MHZ),
   .FMAX_MHZ(FMAX_MHZ), .LOCK_TMO(LOCK_TMO), .FREQ_W(FREQ_W)
) u_chk (.*);

// File: tb/sim_pll_retune_seq.sv
module sim_pll_retune_seq;
   localparam int OSC  = 16;
   localparam int FILT = 4;
   localparam int TMO  = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic [5:0] req_mult = '0;
   logic [3:0] req_div = '0;
   logic       pll_lock = 1'b0;
   logic       sel_pll, busy, err;
   logic [5:0] mult_q;
   logic [3:0] div_q;
   logic [7:0] bus_mhz;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pll_retune_seq #(.OSC_MHZ(OSC), .LOCK_FILT(FILT), .LOCK_TMO(TMO)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_mult(req_mult), .req_div(req_div),
      .pll_lock(pll_lock), .sel_pll(sel_pll), .mult_q(mult_q), .div_q(div_q),
      .busy(busy), .err(err), .bus_mhz(bus_mhz)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_bus(input int m, input int d);
      return (OSC * (m + 1)) / (d + 1);
   endfunction

   // Pulse a request; returns at the falling edge after E0.
   task automatic pulse_req(input int m, input int d);
      @(negedge clk);
      req = 1'b1; req_mult = 6'(m); req_div = 4'(d);
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 sel_pll", sel_pll, 0);
      check("R1 busy", busy, 0);
      check("R1 err", err, 0);
      check("R1 mult_q", mult_q, 0);
      check("R1 div_q", div_q, 0);
      check("R1 bus_mhz", bus_mhz, OSC);
   endtask

   task automatic t_accept(input int m, input int d, input string tag);
      int pm = mult_q, pd = div_q;
      pll_lock = 1'b1;
      pulse_req(m, d);
      check({"R2 busy at E0 ", tag}, busy, 1);
      check({"R2 osc at E0 ", tag}, sel_pll, 0);
      check({"R2 bus osc ", tag}, bus_mhz, OSC);
      check({"R2 mult held at E0 ", tag}, mult_q, pm);
      check({"R2 div held at E0 ", tag}, div_q, pd);
      @(negedge clk);
      check({"R3 mult written ", tag}, mult_q, m);
      check({"R3 div written ", tag}, div_q, d);
      repeat (FILT - 1) @(negedge clk);
      check({"R6 not yet selected ", tag}, sel_pll, 0);
      @(negedge clk);
      check({"R8 pll selected ", tag}, sel_pll, 1);
      check({"R8 busy low ", tag}, busy, 0);
      check({"R3 bus freq ", tag}, bus_mhz, exp_bus(m, d));
      check({"R10 err clear ", tag}, err, 0);
   endtask

   task automatic t_reject(input int m, input int d, input string tag);
      int pm = mult_q, pd = div_q;
      pll_lock = 1'b1;
      pulse_req(m, d);
      check({tag, " busy at E0"}, busy, 1);
      @(negedge clk);
      check({tag, " err"}, err, 1);
      check({tag, " busy"}, busy, 0);
      check({tag, " sel_pll"}, sel_pll, 0);
      check({tag, " bus osc"}, bus_mhz, OSC);
      check({tag, " mult kept"}, mult_q, pm);
      check({tag, " div kept"}, div_q, pd);
      repeat (FILT + 2) @(negedge clk);
      check({tag, " still on osc"}, sel_pll, 0);
   endtask

   task automatic t_glitch();
      pll_lock = 1'b0;
      pulse_req(8, 15);
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         pll_lock = 1'b1;
         repeat (FILT - 1) @(negedge clk);
         pll_lock = 1'b0;
         @(negedge clk);
      end
      check("R6 short lock runs ignored sel", sel_pll, 0);
      check("R6 short lock runs ignored busy", busy, 1);
      pll_lock = 1'b1;
      repeat (FILT - 1) @(negedge clk);
      check("R6 run not complete", sel_pll, 0);
      @(negedge clk);
      check("R6 full run selects", sel_pll, 1);
      check("R6 bus 9", bus_mhz, 9);
   endtask

   task automatic t_timeout();
      pll_lock = 1'b0;
      pulse_req(2, 1);
      @(negedge clk);
      repeat (TMO - 1) @(negedge clk);
      check("R7 busy before expiry", busy, 1);
      check("R7 err before expiry", err, 0);
      @(negedge clk);
      check("R7 busy after expiry", busy, 0);
      check("R7 err after expiry", err, 1);
      check("R7 osc kept", sel_pll, 0);
      check("R7 bus osc", bus_mhz, OSC);
      pll_lock = 1'b1;
      repeat (6) @(negedge clk);
      check("R10 err sticky", err, 1);
      check("R10 no late select", sel_pll, 0);
      pulse_req(0, 0);
      check("R10 err cleared at E0", err, 0);
      @(negedge clk);
      repeat (FILT) @(negedge clk);
      check("R10 retry selects", sel_pll, 1);
      check("R10 retry bus 16", bus_mhz, 16);
   endtask

   task automatic t_busy_ignore();
      pll_lock = 1'b0;
      pulse_req(2, 1);
      @(negedge clk);
      req = 1'b1; req_mult = 6'd0; req_div = 4'd0;
      @(negedge clk);
      req = 1'b0;
      check("R9 mult unchanged", mult_q, 2);
      check("R9 div unchanged", div_q, 1);
      pll_lock = 1'b1;
      repeat (FILT) @(negedge clk);
      check("R9 selected", sel_pll, 1);
      check("R9 bus 24", bus_mhz, 24);
      repeat (3) @(negedge clk);
      check("R9 no second sequence", busy, 0);
      check("R9 still on pll", sel_pll, 1);
      check("R9 mult final", mult_q, 2);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_accept(2, 1, "24");
      t_accept(8, 15, "9");
      t_accept(0, 1, "low edge 8");
      t_accept(24, 15, "high edge 25");
      t_accept(0, 0, "16");
      t_reject(0, 2, "R4 non-integer");
      t_reject(12, 7, "R5 above 52");
      t_reject(6, 15, "R5 below 14");
      t_reject(3, 0, "R5 far above 128");
      t_glitch();
      t_timeout();
      t_busy_ignore();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule